// File: doc/BRIEF.md
# Fixed-Point Time-of-Day Counter

This block keeps a 64-bit nanosecond time of day for a packet-timing clock. On every enabled clock cycle a fixed-point period is added to a running counter. The period has a 10-bit integer part in nanoseconds and a 32-bit fractional part. The fractional part feeds a 32-bit accumulator, and the accumulator's carry-out adds one extra nanosecond on the cycle it occurs. Software can therefore trim the rate in steps far finer than one nanosecond per cycle.

A separately programmable 64-bit offset is added to the counter to form the reported current time. Moving the offset shifts time without touching the counter. Every alarm comparator watches the current time. When the current time reaches its programmed value, the alarm sets a sticky event bit. The event bits are masked and combined into one interrupt line.

All programming goes through a plain 32-bit word-addressed register bus. Each 64-bit quantity is reached as a low half and a high half, through shadow registers, so that both halves always change together. A read returns its data one cycle after the request. The bus has no back-pressure: a write or a read is accepted in every cycle in which it is presented.

Top module: `ptc_timer`

## Requirements
- R1: After reset, the current time is 0 and the irq output is low. The timer is disabled. The control register (word 0) reads 0x0004_0000, with integer period 4 in bits [25:16] and enable bit 2 clear. Both alarm values read all-ones, and the event register (word 2) reads 0.
- R2: While enabled, each clock cycle adds the integer period plus the carry-out of a 32-bit fractional accumulator to the counter. The fractional accumulator adds the fraction register (word 1) to itself every enabled cycle.
- R3: Writing bits [25:16] of the control register only stages a new integer period. The staged value and the new fraction both take effect at a write to word 1. That write also clears the fractional accumulator.
- R4: Each 64-bit register is split into a low word and a high word. The pairs are the counter (words 4/5), the offset (words 6/7), and alarm i (words 10+2i / 11+2i). A write to a low word changes only a shadow. A write to the high word loads {high data, shadow} into the live register in that cycle.
- R5: Reading the current-time low word (word 8) returns the low 32 bits and freezes the high 32 bits of that same instant. A later read of word 9 returns the frozen high half.
- R6: The current time equals counter plus offset, modulo 2^64. Writing the offset changes neither the counter nor its stepping. The counter low word reads back at word 4.
- R7: Control bit 2 is the enable. While it is clear the counter holds its value. Writes to the counter, offset and alarm words are ignored while it is clear.
- R8: Alarm i sets event bit 16+i in the cycle after the current time is greater than or equal to its value. It fires only once, until its high word is written again.
- R9: An alarm whose value is all-ones is idle and never sets its event bit.
- R10: Writing a one to an event bit clears it. The irq output is high whenever any event bit is set together with its bit in the mask register (word 3).
- R11: Read data appears on bus_rdata on the clock edge after bus_rd is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one counter step per enabled cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| time_now | output | 64 | Current time, counter plus offset |
| irq | output | 1 | Masked OR of the event bits |

## Verification
Each result has a fixed latency, and every check is timed to it.
- A register write lands on the first edge after the strobe, so the effect of a load or an offset change is checked at the falling edge that follows.
- A counter step appears one edge after the enable is set, and the bench tracks each later step cycle by cycle with its own accumulator model.
- An alarm event follows one edge after the current time reaches the alarm value, so the first irq must coincide with time equal to the alarm value plus one period.
- Read data is sampled one falling edge after the capturing rising edge, and current-time snapshots are compared against the time_now value seen in the cycle the read was presented.

// File: rtl/ptc_pkg.sv
`timescale 1ns/1ps
package ptc_pkg;
  localparam int DW      = 32;
  // word addresses
  localparam int A_CTRL  = 0;
  localparam int A_FRAC  = 1;
  localparam int A_EVT   = 2;
  localparam int A_MASK  = 3;
  localparam int A_CNT_L = 4;
  localparam int A_CNT_H = 5;
  localparam int A_OFF_L = 6;
  localparam int A_OFF_H = 7;
  localparam int A_NOW_L = 8;
  localparam int A_NOW_H = 9;
  localparam int A_ALM   = 10;  // alarm i low at A_ALM+2i, high at A_ALM+2i+1
  // control and event field positions
  localparam int EN_BIT  = 2;
  localparam int INT_LSB = 16;
  localparam int EVT_LSB = 16;
endpackage

// File: rtl/ptc_rate.sv
`timescale 1ns/1ps
module ptc_rate #(
  parameter int INT_W   = 10,
  parameter int FRAC_W  = 32,
  parameter int TIME_W  = 64,
  parameter int INT_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [INT_W-1:0]  int_stage,
  input  logic              frac_wr,
  input  logic [FRAC_W-1:0] frac_wdata,
  input  logic              load,
  input  logic [TIME_W-1:0] load_val,
  output logic [TIME_W-1:0] cnt,
  output logic [INT_W-1:0]  int_live
);
  logic [FRAC_W-1:0] frac_live;
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   sum;

  assign sum = {1'b0, acc} + {1'b0, frac_live};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_live  <= INT_W'(INT_RST);
      frac_live <= '0;
      acc       <= '0;
    end else if (frac_wr) begin
      int_live  <= int_stage;
      frac_live <= frac_wdata;
      acc       <= '0;
    end else if (step) begin
      acc <= sum[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (step)
      cnt <= cnt + TIME_W'(int_live) + TIME_W'(sum[FRAC_W]);
  end
endmodule

// File: rtl/ptc_alarm.sv
`timescale 1ns/1ps
module ptc_alarm #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  input  logic [2*DW-1:0] now,
  output logic [2*DW-1:0] value,
  output logic          hit
);
  logic [DW-1:0] lo_sh;
  logic          armed;

  assign hit = armed && (value != '1) && (now >= value);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_sh <= '0;
      value <= '1;
      armed <= 1'b0;
    end else begin
      if (wr_lo) lo_sh <= wdata;
      if (wr_hi) begin
        value <= {wdata, lo_sh};
        armed <= 1'b1;
      end else if (hit) begin
        armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ptc_timer.sv
`timescale 1ns/1ps
module ptc_timer
  import ptc_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int INT_W   = 10,
  parameter int N_ALARM = 2,
  parameter int INT_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [2*DW-1:0]   time_now,
  output logic              irq
);
  localparam int TW = 2 * DW;

  logic               ctrl_en;
  logic [INT_W-1:0]   int_stage;
  logic [INT_W-1:0]   rate_int;
  logic [DW-1:0]      mask_q;
  logic [N_ALARM-1:0] evt_q;
  logic [N_ALARM-1:0] hits;
  logic [DW-1:0]      cnt_lo_sh, off_lo_sh, now_hi_snap;
  logic [TW-1:0]      offset, cnt;
  logic [TW-1:0]      alm_val [N_ALARM];
  logic               twr;
  logic [DW-1:0]      rd_mux, ctrl_word, evt_word;

  function automatic logic is_a(input logic [ADDR_W-1:0] a, input int n);
    return a == ADDR_W'(n);
  endfunction

  assign twr      = bus_wr && ctrl_en;
  assign time_now = cnt + offset;
  assign irq      = |(evt_q & mask_q[EVT_LSB +: N_ALARM]);

  ptc_rate #(.INT_W(INT_W), .FRAC_W(DW), .TIME_W(TW), .INT_RST(INT_RST)) u_rate (
    .clk(clk), .rst_n(rst_n), .step(ctrl_en),
    .int_stage(int_stage),
    .frac_wr(bus_wr && is_a(bus_addr, A_FRAC)), .frac_wdata(bus_wdata),
    .load(twr && is_a(bus_addr, A_CNT_H)), .load_val({bus_wdata, cnt_lo_sh}),
    .cnt(cnt), .int_live(rate_int)
  );

  for (genvar gi = 0; gi < N_ALARM; gi++) begin : g_alm
    ptc_alarm #(.DW(DW)) u_alm (
      .clk(clk), .rst_n(rst_n),
      .wr_lo(twr && is_a(bus_addr, A_ALM + 2*gi)),
      .wr_hi(twr && is_a(bus_addr, A_ALM + 2*gi + 1)),
      .wdata(bus_wdata), .now(time_now),
      .value(alm_val[gi]), .hit(hits[gi])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      int_stage <= INT_W'(INT_RST);
      mask_q    <= '0;
      evt_q     <= '0;
      cnt_lo_sh <= '0;
      off_lo_sh <= '0;
      offset    <= '0;
    end else begin
      if (bus_wr && is_a(bus_addr, A_CTRL)) begin
        ctrl_en   <= bus_wdata[EN_BIT];
        int_stage <= bus_wdata[INT_LSB +: INT_W];
      end
      if (bus_wr && is_a(bus_addr, A_MASK)) mask_q <= bus_wdata;
      if (bus_wr && is_a(bus_addr, A_EVT))
        evt_q <= (evt_q & ~bus_wdata[EVT_LSB +: N_ALARM]) | hits;
      else
        evt_q <= evt_q | hits;
      if (twr && is_a(bus_addr, A_CNT_L)) cnt_lo_sh <= bus_wdata;
      if (twr && is_a(bus_addr, A_OFF_L)) off_lo_sh <= bus_wdata;
      if (twr && is_a(bus_addr, A_OFF_H)) offset <= {bus_wdata, off_lo_sh};
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[EN_BIT] = ctrl_en;
    ctrl_word[INT_LSB +: INT_W] = int_stage;
    evt_word = '0;
    evt_word[EVT_LSB +: N_ALARM] = evt_q;
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(A_CTRL):  rd_mux = ctrl_word;
      ADDR_W'(A_EVT):   rd_mux = evt_word;
      ADDR_W'(A_MASK):  rd_mux = mask_q;
      ADDR_W'(A_CNT_L): rd_mux = cnt[DW-1:0];
      ADDR_W'(A_CNT_H): rd_mux = cnt[TW-1:DW];
      ADDR_W'(A_OFF_L): rd_mux = offset[DW-1:0];
      ADDR_W'(A_OFF_H): rd_mux = offset[TW-1:DW];
      ADDR_W'(A_NOW_L): rd_mux = time_now[DW-1:0];
      ADDR_W'(A_NOW_H): rd_mux = now_hi_snap;
      default:          rd_mux = '0;
    endcase
    for (int i = 0; i < N_ALARM; i++) begin
      if (is_a(bus_addr, A_ALM + 2*i))     rd_mux = alm_val[i][DW-1:0];
      if (is_a(bus_addr, A_ALM + 2*i + 1)) rd_mux = alm_val[i][TW-1:DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata   <= '0;
      now_hi_snap <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
      if (is_a(bus_addr, A_NOW_L)) now_hi_snap <= time_now[TW-1:DW];
    end
  end
endmodule

// File: rtl/ptc_timer_chk.sv
`timescale 1ns/1ps
module ptc_timer_chk #(
  parameter int ADDR_W = 4,
  parameter int INT_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              ctrl_en,
  input logic [INT_W-1:0]  rate_int,
  input logic [63:0]       offset,
  input logic [63:0]       time_now,
  input logic [63:0]       alm0,
  input logic              evt0
);
  // R7: a disabled timer holds its time
  a_r7_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> $stable(time_now));
  // R3: live integer period changes only on a fraction write
  a_r3_int_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == ADDR_W'(1)) |=> $stable(rate_int));
  // R4: a low-half offset write leaves the live offset alone
  a_r4_off_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(6)) |=> $stable(offset));
  // R8: an alarm event only rises after the time reached the alarm
  a_r8_reached: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt0) |-> ($past(time_now) >= $past(alm0)));
  // R9: an all-ones alarm is idle
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (alm0 == '1) |=> !$rose(evt0));
endmodule

bind ptc_timer ptc_timer_chk #(.ADDR_W(ADDR_W), .INT_W(INT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .ctrl_en(ctrl_en), .rate_int(rate_int), .offset(offset),
  .time_now(time_now), .alm0(alm_val[0]), .evt0(evt_q[0])
);

// File: tb/test_ptc_timer.sv
`timescale 1ns/1ps
module test_ptc_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] time_now;
  logic        irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ptc_timer i_ptc_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .time_now(time_now), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d, output logic [63:0] tn);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 4'(a); tn = time_now;
    @(negedge clk);
    bus_rd = 1'b0; d = bus_rdata;
  endtask

  function automatic logic [31:0] ctl(input int iv, input bit en);
    return (32'(iv) << 16) | (en ? 32'h4 : 32'h0);
  endfunction

  task automatic set_rate(input int iv, input logic [31:0] fr);
    wr(0, ctl(iv, 0));
    wr(1, fr);
    wr(0, ctl(iv, 1));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] tn, prev, al;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R11 read latency
    chk("R1 time", time_now, 64'd0);
    chk("R1 irq", {63'd0, irq}, 64'd0);
    rd(0, d, tn); chk("R1 R11 ctrl", {32'd0, d}, 64'h0004_0000);
    rd(10, d, tn); chk("R1 alarm0 lo", {32'd0, d}, 64'hFFFF_FFFF);
    rd(13, d, tn); chk("R1 alarm1 hi", {32'd0, d}, 64'hFFFF_FFFF);
    rd(2, d, tn); chk("R1 events", {32'd0, d}, 64'd0);
    // R7 disabled: no counting, time writes ignored
    repeat (5) @(negedge clk);
    chk("R7 hold", time_now, 64'd0);
    wr(4, 32'h55); wr(5, 32'h1); wr(6, 32'h9); wr(7, 32'h0);
    chk("R7 writes ignored", time_now, 64'd0);
    rd(4, d, tn); chk("R7 counter", {32'd0, d}, 64'd0);

    // R2/R3 rate sweep with a bench accumulator model
    for (int p = 0; p < 6; p++) begin
      int iv; logic [31:0] fr; logic [31:0] acc; logic [32:0] s;
      case (p)
        0: begin iv = 1;    fr = 32'h0; end
        1: begin iv = 1;    fr = 32'h8000_0000; end
        2: begin iv = 3;    fr = 32'h4000_0000; end
        3: begin iv = 2;    fr = 32'hFFFF_FFFF; end
        4: begin iv = 1023; fr = 32'h1234_5678; end
        default: begin iv = 5; fr = 32'h0000_0001; end
      endcase
      set_rate(iv, fr);
      acc = '0;
      prev = time_now;
      for (int k = 0; k < 24; k++) begin
        @(negedge clk);
        s = {1'b0, acc} + {1'b0, fr};
        acc = s[31:0];
        chk("R2 step", time_now - prev, 64'(iv) + 64'(s[32]));
        prev = time_now;
      end
      wr(0, ctl(iv, 0));
    end

    // R3 staged integer period
    set_rate(3, 32'h0);
    wr(0, ctl(7, 1));
    prev = time_now;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); chk("R3 staged unused", time_now - prev, 64'd3); prev = time_now;
    end
    wr(1, 32'h0);
    prev = time_now;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); chk("R3 committed", time_now - prev, 64'd7); prev = time_now;
    end

    // R4 shadow commit on the counter, R6 offset
    set_rate(1, 32'h0);
    wr(4, 32'h0000_0100);
    prev = time_now;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); chk("R4 low only", time_now - prev, 64'd1); prev = time_now;
    end
    wr(5, 32'h2);
    chk("R4 commit", time_now, 64'h2_0000_0100);
    wr(6, 32'h50);
    prev = time_now;
    @(negedge clk); chk("R4 offset low only", time_now - prev, 64'd1);
    wr(7, 32'h0);
    rd(4, d, tn); chk("R6 offset add", {32'd0, tn[31:0] - d}, 64'h50);
    prev = time_now;
    @(negedge clk); chk("R6 counter undisturbed", time_now - prev, 64'd1);
    wr(6, 32'hFFFF_FFF0); wr(7, 32'hFFFF_FFFF);
    rd(4, d, tn); chk("R6 negative offset", {32'd0, tn[31:0] - d}, 64'hFFFF_FFF0);
    wr(6, 32'h0); wr(7, 32'h0);

    // R5 coherent current-time read across a 32-bit carry
    wr(4, 32'hFFFF_FFF0); wr(5, 32'h4);
    rd(8, d, tn);
    chk("R5 low", {32'd0, d}, {32'd0, tn[31:0]});
    repeat (40) @(negedge clk);
    chk("R5 carried", {32'd0, time_now[63:32]}, 64'd5);
    rd(9, d, tn); chk("R5 frozen high", {32'd0, d}, 64'd4);

    // R8/R10 alarm 0 with irq
    wr(4, 32'h1000); wr(5, 32'h0);
    wr(3, 32'h0001_0000);
    al = time_now + 64'd20;
    wr(10, al[31:0]); wr(11, al[63:32]);
    tn = '0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (irq && tn == 64'd0) tn = time_now;
    end
    chk("R8 fire time", tn, al + 64'd1);
    rd(2, d, tn); chk("R8 event bit 16", {32'd0, d}, 64'h0001_0000);
    wr(2, 32'h0001_0000);
    chk("R10 w1c irq", {63'd0, irq}, 64'd0);
    repeat (10) @(negedge clk);
    rd(2, d, tn); chk("R8 once", {32'd0, d}, 64'd0);
    // alarm 1 masked off
    al = time_now + 64'd10;
    wr(12, al[31:0]); wr(13, al[63:32]);
    repeat (30) @(negedge clk);
    chk("R10 masked", {63'd0, irq}, 64'd0);
    rd(2, d, tn); chk("R8 event bit 17", {32'd0, d}, 64'h0002_0000);
    wr(3, 32'h0002_0000);
    chk("R10 unmasked", {63'd0, irq}, 64'd1);
    wr(2, 32'h0002_0000);
    wr(3, 32'h0001_0000);
    // rearm alarm 0 in the past
    al = time_now - 64'd5;
    wr(10, al[31:0]); wr(11, al[63:32]);
    @(negedge clk);
    chk("R8 rearm", {63'd0, irq}, 64'd1);
    wr(2, 32'h0001_0000);

    // R9 idle alarm through a full wrap
    wr(10, 32'hFFFF_FFFF); wr(11, 32'hFFFF_FFFF);
    wr(2, 32'h0003_0000);
    wr(3, 32'h0003_0000);
    wr(4, 32'hFFFF_FFF0); wr(5, 32'hFFFF_FFFF);
    tn = '0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (irq) tn = 64'd1;
    end
    chk("R9 idle", tn, 64'd0);
    chk("R9 wrapped", {63'd0, time_now < 64'h100}, 64'd1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule